// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Core

This block is a clocked single-port memory with flow-through reads and late writes. A read shows its word on the output in the same cycle its address is taken. A write takes its address, direction and byte enables on one rising edge, and takes its data on the next enabled edge. Read and write commands can therefore alternate on every edge, and the data bus never needs an idle cycle between them.

A command starts on an edge where the clock enable is low, the load control is low and all three selects are active. If load is low and any select is inactive, the block is deselected. With load high, the current operation goes on as a burst. The next burst address comes from an external counter block on `burst_addr`.

Read data leaves on `rdata` with a `rvalid` flag. There is no ready signal: a flow-through memory cannot stall its read port. The only back-pressure is the clock enable, which freezes the whole core, and the held word is shown again. When `rvalid` is low, `rdata` is driven to zero. This takes the place of a high-impedance bus.

Top module: `ntsram_core`

## Requirements
- R1: A new command is taken only on a rising edge with `cke_n`=0, `ld_n`=0, `cs1_n`=0, `cs2`=1 and `cs3_n`=0. `we_n`=1 selects a read and `we_n`=0 selects a write, both at `addr`.
- R2: An edge with `cke_n`=0, `ld_n`=0 and any select inactive deselects the core. After it there is no read output, and no write is queued.
- R3: An edge with `ld_n`=1 that follows a deselect leaves the core deselected.
- R4: For a write, the address and the byte enables are taken on the command edge. `wdata` is written on the next edge with `cke_n`=0.
- R5: `bw_n[i]` is active low and controls byte i, which is `wdata[8i+7:8i]`. If all bits are high the write is aborted, and the word is left unchanged.
- R6: After a read edge, `rdata` shows the stored word at the captured address before the next edge.
- R7: `rvalid` is 1 only while a read is active and `oe_n`=0. Otherwise `rvalid`=0 and `rdata`=0. `oe_n` acts without waiting for a clock edge.
- R8: While `cke_n`=1, every edge is ignored. A queued write keeps waiting for its data, and a read output stays the same.
- R9: An edge with `ld_n`=1 after a read or write goes on with the same kind of operation at `burst_addr`.
- R10: A read of an address issued on the edge right after that address's write command returns the newly written data.
- R11: Reset clears the queued write and leaves the core deselected, with `rvalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| cs1_n | input | 1 | Select, active low |
| cs2 | input | 1 | Select, active high |
| cs3_n | input | 1 | Select, active low |
| ld_n | input | 1 | Low loads a new command; high advances the burst |
| we_n | input | 1 | Low = write, high = read (sampled at load) |
| bw_n | input | NBYTES | Active-low byte enables |
| addr | input | ADDR_W | Command address |
| burst_addr | input | ADDR_W | Next burst address from the external counter |
| wdata | input | NBYTES*BYTE_W | Write data, one enabled edge after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | NBYTES*BYTE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench sends a write command and then, on the next edge, a read of the same address. A core that lands the data one edge late would return the old word there. It holds `cke_n` high between a write command and its data edge. A core that takes `wdata` on a disabled edge would store the wrong word. It also tries partial and all-high byte masks, bursts that continue through `ld_n` after reads, writes and deselects, and each select dropped on its own. Random mixed traffic against a bench-side model then exposes a wrong byte lane, a burst that switches type, or an output that still drives after `oe_n` rises.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ntsram_ctrl.sv
module ntsram_ctrl
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              ld_n,
  input  logic              sel_ok,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] burst_addr,
  output op_e               op_d,
  output logic [ADDR_W-1:0] addr_d,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q
);
  // next operation: load a fresh command, deselect, or continue the burst
  always_comb begin
    op_d   = op_q;
    addr_d = burst_addr;
    if (!ld_n) begin
      addr_d = addr;
      if (sel_ok) op_d = we_n ? OP_READ : OP_WRITE;
      else        op_d = OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
    end else if (!cke_n) begin
      op_q   <= op_d;
      addr_q <= addr_d;
    end
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && !sel_ok) |=> (op_q == OP_IDLE)); // R2
  AST_CONT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && ld_n && op_q == OP_IDLE) |=> (op_q == OP_IDLE)); // R3
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(op_q) && $stable(addr_q))); // R8
  AST_BURST_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && ld_n && op_q != OP_IDLE) |=> $stable(op_q)); // R9
endmodule

// File: rtl/ntsram_wstage.sv
module ntsram_wstage
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  op_e               op_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [NBYTES-1:0] bw_n,
  output logic              pend_vld,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [NBYTES-1:0] wr_mask
);
  // address and mask wait here one enabled edge for their data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      wr_addr  <= '0;
      wr_mask  <= '0;
    end else if (!cke_n) begin
      pend_vld <= (op_d == OP_WRITE);
      wr_addr  <= addr_d;
      wr_mask  <= ~bw_n;
    end
  end

  assign wr_en = pend_vld && !cke_n;

  AST_PEND_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && pend_vld) |=> (pend_vld && $stable(wr_addr) && $stable(wr_mask))); // R8
endmodule

// File: rtl/ntsram_array.sv
module ntsram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_mask,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b])
        lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
    end
    assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
  end
endmodule

// File: rtl/ntsram_core.sv
module ntsram_core
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     cs1_n,
  input  logic                     cs2,
  input  logic                     cs3_n,
  input  logic                     ld_n,
  input  logic                     we_n,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-1:0]        burst_addr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  input  logic                     oe_n,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     rvalid
);
  localparam int DW = NBYTES * BYTE_W;

  logic              sel_ok;
  op_e               op_d, op_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              pend_vld, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [NBYTES-1:0] wr_mask;
  logic [DW-1:0]     arr_rd;

  assign sel_ok = !cs1_n && cs2 && !cs3_n;

  ntsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .sel_ok(sel_ok),
    .we_n(we_n), .addr(addr), .burst_addr(burst_addr),
    .op_d(op_d), .addr_d(addr_d), .op_q(op_q), .addr_q(addr_q)
  );

  ntsram_wstage #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_wstage (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .op_d(op_d), .addr_d(addr_d),
    .bw_n(bw_n), .pend_vld(pend_vld), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_mask(wr_mask)
  );

  // data lands in the array on the edge after its command; the read port
  // sees it combinationally, so a read right behind the write gets new data
  ntsram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .wr_data(wdata), .rd_addr(addr_q), .rd_data(arr_rd)
  );

  assign rvalid = (op_q == OP_READ) && !oe_n;
  assign rdata  = rvalid ? arr_rd : '0;

  AST_LATE_WRITE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && sel_ok && !we_n) |=> pend_vld); // R4
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rvalid && rdata == '0)); // R7
  AST_NO_START_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && !sel_ok) |=> !pend_vld); // R1
endmodule

// File: tb/test_ntsram_core.sv
module test_ntsram_core;
  localparam int AW = 6, NB = 4, BW = 8, DW = NB * BW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cke_n = 1'b0, ld_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0, baddr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rvalid;

  ntsram_core #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) i_ntsram_core (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .burst_addr(baddr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model: 0 idle, 1 read, 2 write
  int            m_op = 0;
  logic [AW-1:0] m_ra = '0, m_pa = '0;
  logic          m_pv = 0;
  logic [NB-1:0] m_pm = '0;
  logic [DW-1:0] mem_m [DEPTH];

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NB-1:0] mask);
    logic [DW-1:0] r = old_w;
    for (int b = 0; b < NB; b++)
      if (mask[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
    return r;
  endfunction

  function automatic logic exp_vld();
    return (m_op == 1) && !oe_n;
  endfunction

  function automatic logic [DW-1:0] exp_data();
    return exp_vld() ? mem_m[m_ra] : '0;
  endfunction

  task automatic model_edge();
    logic [AW-1:0] a;
    if (cke_n) return;
    if (m_pv) mem_m[m_pa] = merge(mem_m[m_pa], wdata, m_pm);
    if (!ld_n) begin
      a = addr;
      if (!cs1_n && cs2 && !cs3_n) m_op = we_n ? 1 : 2;
      else                         m_op = 0;
    end else begin
      a = baddr;
    end
    m_pv = (m_op == 2);
    m_pa = a;
    m_pm = ~bw_n;
    m_ra = a;
  endtask

  task automatic check(string tag);
    n_cmp++;
    if (rvalid !== exp_vld()) begin
      n_bad++;
      $display("FAIL %s rvalid actual=%b expected=%b t=%0t", tag, rvalid, exp_vld(), $time);
    end
    n_cmp++;
    if (rdata !== exp_data()) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h t=%0t", tag, rdata, exp_data(), $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    #2;
    check(tag);
  endtask

  task automatic set_cmd(bit c_n, bit l_n, bit sel, bit w_n, logic [NB-1:0] b,
                         logic [AW-1:0] a, logic [AW-1:0] ba);
    cke_n = c_n; ld_n = l_n; we_n = w_n; bw_n = b; addr = a; baddr = ba;
    cs1_n = 1'b0; cs2 = sel; cs3_n = 1'b0;
    wdata = {$urandom, $urandom};
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check("R11");                                      // R11 idle after reset
    // pending write must be clear: a continue edge after reset writes nothing
    set_cmd(0, 1, 1, 0, '0, 0, 0); step("R11");

    // fill memory with full-word writes (late data: R4)
    for (int a = 0; a < DEPTH; a++) begin
      set_cmd(0, 0, 1, 0, '0, a[AW-1:0], 0); step("R4");
    end
    set_cmd(0, 0, 0, 1, '1, 0, 0); step("R4");

    // R10 read right behind write
    set_cmd(0, 0, 1, 0, '0, 5, 0); step("R4");
    set_cmd(0, 0, 1, 1, '1, 5, 0); step("R10");

    // R5 partial and aborted byte writes
    set_cmd(0, 0, 1, 0, 4'b1010, 7, 0); step("R5");
    set_cmd(0, 0, 1, 1, '1, 7, 0); step("R5");
    set_cmd(0, 0, 1, 0, 4'b1111, 7, 0); step("R5");
    set_cmd(0, 0, 1, 1, '1, 7, 0); step("R5");

    // R1/R2: each select dropped alone
    set_cmd(0, 0, 1, 0, '0, 9, 0); cs1_n = 1'b1; step("R2");
    set_cmd(0, 0, 1, 1, '1, 9, 0); cs3_n = 1'b1; step("R1");
    set_cmd(0, 0, 1, 1, '1, 9, 0); step("R2");
    set_cmd(0, 0, 0, 0, '0, 9, 0); step("R1");
    set_cmd(0, 0, 1, 1, '1, 9, 0); step("R1");

    // R3 continue after deselect
    set_cmd(0, 0, 0, 1, '1, 3, 0); step("R3");
    set_cmd(0, 1, 1, 0, '0, 3, 4); step("R3");
    set_cmd(0, 1, 1, 1, '0, 3, 6); step("R3");

    // R9 read burst then write burst
    set_cmd(0, 0, 1, 1, '1, 10, 0); step("R9");
    set_cmd(0, 1, 1, 0, '0, 0, 11); step("R9");
    set_cmd(0, 1, 1, 0, '0, 0, 12); step("R9");
    set_cmd(0, 0, 1, 0, '0, 20, 0); step("R9");
    set_cmd(0, 1, 1, 1, '0, 0, 21); step("R9");
    set_cmd(0, 0, 1, 1, '1, 21, 0); step("R9");
    set_cmd(0, 0, 1, 1, '1, 20, 0); step("R9");

    // R8 clock enable high holds pending write and read output
    set_cmd(0, 0, 1, 0, '0, 30, 0); step("R8");
    set_cmd(1, 0, 1, 1, '1, 31, 0); step("R8");
    set_cmd(1, 0, 1, 1, '1, 32, 0); step("R8");
    set_cmd(0, 0, 1, 1, '1, 30, 0); step("R8");
    set_cmd(1, 0, 1, 0, '0, 2, 0); step("R8");

    // R7 asynchronous output enable
    set_cmd(0, 0, 1, 1, '1, 4, 0); step("R6");
    oe_n = 1'b1; #1 check("R7");
    oe_n = 1'b0; #1 check("R7");

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      set_cmd(($urandom % 8) == 0, ($urandom % 3) == 0, 1, $urandom % 2,
              NB'($urandom), AW'($urandom), AW'($urandom));
      if (($urandom % 8) == 0) cs1_n = 1'b1;
      if (($urandom % 8) == 0) cs3_n = 1'b1;
      oe_n = (($urandom % 6) == 0);
      step("R6");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule